// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs accesses from an internal requester onto a 16-bit external bus split into two chip-select regions. An accepted request drives the word address and one region's chip select. It then drives either the read strobe or the byte-lane write strobes. The strobes are held for a per-region count of one to four wait cycles, and they stay on for as long as the active-low wait input is sampled low. When the access ends, a one-cycle done pulse returns the read data with any unrequested byte cleared.

An address outside both regions is answered with an error pulse and causes no bus activity. An external master can take the bus with an active-low hold request. The controller first finishes any access in progress. It then drives all strobes inactive, stops driving data and asserts hold acknowledge. It accepts no internal request until the hold request is removed.

Top module: `ebus_waitctl`

## Requirements
- R1: During reset and in the first cycle after it, both chip selects, the read strobe and both write strobes are high, hold_ack_n is high, rsp_done is low and bus_oe is low.
- R2: The region is taken from address bits [ADDR_W-1:SEL_LSB]: a value of 0 selects cs_n[0] and a value of 1 selects cs_n[1]. At most one chip select is low at any time, and while it is low bus_addr carries req_addr[ADDR_W-1:1] of the access.
- R3: The region's 2-bit wait setting c (wait_cfg0 for region 0, wait_cfg1 for region 1) programs c+1 wait cycles. With wait_n held high, the chip select and strobe are low for exactly c+2 cycles, counted from the cycle after the accepting edge.
- R4: Once the programmed wait cycles are used up, each rising edge that samples wait_n low extends the access by one cycle. The access ends on the first edge that samples wait_n high.
- R5: During a write, wrh_n is low only if req_be[1] is set and wrl_n is low only if req_be[0] is set; bus_oe is high and bus_dout carries the write data. rd_n stays high.
- R6: rd_n is low only during read accesses, and no write strobe is low then. The returned rsp_rdata carries bus_din as sampled on the completing edge, with bits [15:8] forced to 0 when req_be[1] is clear and bits [7:0] forced to 0 when req_be[0] is clear.
- R7: rsp_done pulses for exactly one cycle, in the first cycle after the strobes are released. rsp_err is low on that pulse.
- R8: A request whose region field is neither 0 nor 1 is answered with rsp_done and rsp_err high in the next cycle. No chip select or strobe goes low for it.
- R9: When hold_req_n is low while the controller is idle, hold_ack_n goes low on the next cycle. If an access is in progress, that access completes first. While hold_ack_n is low, all chip selects and strobes are high and bus_oe is low.
- R10: req_ready is high only when the controller is idle and hold_req_n is high. A request held during an access or during hold is not started. After hold_req_n returns high, hold_ack_n goes high before any new access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_cfg0 | input | 2 | Region 0 wait setting (c gives c+1 wait cycles) |
| wait_cfg1 | input | 2 | Region 1 wait setting |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the request |
| req_be | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an out-of-region error |
| rsp_rdata | output | 16 | Read data, unrequested bytes zero |
| bus_addr | output | ADDR_W-1 | External word address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | External data drive enable |
| bus_din | input | 16 | External read data |
| cs_n | output | 2 | Active-low chip selects, one per region |
| rd_n | output | 1 | Active-low read strobe |
| wrh_n | output | 1 | Active-low high-byte write strobe |
| wrl_n | output | 1 | Active-low low-byte write strobe |
| wait_n | input | 1 | Active-low wait extension |
| hold_req_n | input | 1 | Active-low bus hold request |
| hold_ack_n | output | 1 | Active-low hold acknowledge |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a region field in bits 23 to 21. That leaves tags 2 to 7 free for out-of-region requests. Region 0 is set to the shortest wait setting and region 1 to the longest, and a sweep then walks region 0 through all four settings. This covers every strobe length from two to five cycles. The wait input is pulled low for one to three sampled cycles. Hold is requested both in idle and in the middle of an access, with a request pending throughout.

// File: rtl/ebus_waitctl.sv
module ebus_waitctl #(
  parameter int ADDR_W  = 24,
  parameter int SEL_LSB = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wait_cfg0,
  input  logic [1:0]        wait_cfg1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-2:0] bus_addr,
  output logic [15:0]       bus_dout,
  output logic              bus_oe,
  input  logic [15:0]       bus_din,
  output logic [1:0]        cs_n,
  output logic              rd_n,
  output logic              wrh_n,
  output logic              wrl_n,
  input  logic              wait_n,
  input  logic              hold_req_n,
  output logic              hold_ack_n
);
  localparam int SEL_W = ADDR_W - SEL_LSB;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_HOLD} st_t;

  st_t              st;
  logic [2:0]       cnt;
  logic             sel_q, wr_q;
  logic [1:0]       be_q;
  logic [ADDR_W-2:0] addr_q;
  logic [15:0]      wdata_q, rdata_q;
  logic             done_q, err_q;

  wire [SEL_W-1:0] tag  = req_addr[ADDR_W-1:SEL_LSB];
  wire             hit0 = (tag == SEL_W'(0));
  wire             hit1 = (tag == SEL_W'(1));
  wire             act  = (st == S_ACC);
  wire [2:0]       load = {1'b0, hit1 ? wait_cfg1 : wait_cfg0} + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!hold_req_n) begin
            st <= S_HOLD;
          end else if (req_valid) begin
            if (hit0 || hit1) begin
              st      <= S_ACC;
              cnt     <= load;
              sel_q   <= hit1;
              wr_q    <= req_write;
              be_q    <= req_be;
              addr_q  <= req_addr[ADDR_W-1:1];
              wdata_q <= req_wdata;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        S_ACC: begin
          if (cnt != 3'd0) begin
            cnt <= cnt - 3'd1;
          end else if (wait_n) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b0;
            if (!wr_q)
              rdata_q <= {be_q[1] ? bus_din[15:8] : 8'h00,
                          be_q[0] ? bus_din[7:0]  : 8'h00};
          end
        end
        S_HOLD: begin
          if (hold_req_n) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE) && hold_req_n;
  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
  assign rsp_rdata  = rdata_q;
  assign bus_addr   = addr_q;
  assign bus_dout   = wdata_q;
  assign bus_oe     = act && wr_q;
  assign cs_n[0]    = !(act && !sel_q);
  assign cs_n[1]    = !(act && sel_q);
  assign rd_n       = !(act && !wr_q);
  assign wrh_n      = !(act && wr_q && be_q[1]);
  assign wrl_n      = !(act && wr_q && be_q[0]);
  assign hold_ack_n = (st != S_HOLD);
endmodule

// File: rtl/ebus_waitctl_chk.sv
module ebus_waitctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_done,
  input logic       rsp_err,
  input logic       bus_oe,
  input logic [1:0] cs_n,
  input logic       rd_n,
  input logic       wrh_n,
  input logic       wrl_n,
  input logic       hold_req_n,
  input logic       hold_ack_n
);
  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R6
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (wrh_n && wrl_n && !bus_oe));
  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (cs_n == 2'b11 && rd_n && wrh_n && wrl_n && !bus_oe));
  // R9
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(hold_ack_n) |-> $past(!hold_req_n));
  // R7
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b11 && $past(cs_n) != 2'b11) |-> (rsp_done && !rsp_err));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> ($past(cs_n) == 2'b11 && cs_n == 2'b11));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !hold_ack_n |-> !req_ready);
endmodule

bind ebus_waitctl ebus_waitctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .bus_oe(bus_oe), .cs_n(cs_n),
  .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n), .hold_req_n(hold_req_n),
  .hold_ack_n(hold_ack_n)
);

// File: tb/ebus_waitctl_bench.sv
module ebus_waitctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] wait_cfg0 = 2'd0, wait_cfg1 = 2'd3;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic wait_n = 1'b1, hold_req_n = 1'b1;
  logic req_ready, rsp_done, rsp_err, bus_oe, rd_n, wrh_n, wrl_n, hold_ack_n;
  logic [15:0] rsp_rdata, bus_dout;
  logic [22:0] bus_addr;
  logic [1:0] cs_n;

  always #10 clk = ~clk;

  ebus_waitctl u_ebus_waitctl (
    .clk(clk), .rst_n(rst_n), .wait_cfg0(wait_cfg0), .wait_cfg1(wait_cfg1),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_be(req_be),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n),
    .wait_n(wait_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n)
  );

  int vectors = 0, miscompares = 0, cycles = 0;

  // reference model: phase 0 idle, 1 on bus, 2 held off
  int m_phase = 0, m_left = 0;
  bit m_region = 0, m_wr = 0, m_done = 0, m_err = 0;
  logic [1:0] m_be = '0;
  logic [22:0] m_addr = '0;
  logic [15:0] m_wdata = '0, m_rdata = '0;

  always @(posedge clk) begin
    int tag;
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_err = 0; m_rdata = '0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (!hold_req_n) m_phase = 2;
        else if (req_valid) begin
          tag = int'(req_addr[23:21]);
          if (tag > 1) begin m_done = 1; m_err = 1; end
          else begin
            m_phase = 1; m_region = (tag == 1);
            m_left = (tag == 1 ? int'(wait_cfg1) : int'(wait_cfg0)) + 1;
            m_wr = req_write; m_be = req_be; m_addr = req_addr[23:1]; m_wdata = req_wdata;
          end
        end
      end else if (m_phase == 1) begin
        if (m_left > 0) m_left--;
        else if (wait_n) begin
          m_phase = 0; m_done = 1; m_err = 0;
          if (!m_wr) begin
            m_rdata[15:8] = m_be[1] ? bus_din[15:8] : 8'h00;
            m_rdata[7:0]  = m_be[0] ? bus_din[7:0]  : 8'h00;
          end
        end
      end else if (hold_req_n) m_phase = 0;
    end
  end

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit on;
    cycles++;
    #5;
    on = (m_phase == 1);
    if (!rst_n) begin
      check("R1", "cs_n in reset", 32'(cs_n), 32'h3);
      check("R1", "strobes in reset", {29'd0, rd_n, wrh_n, wrl_n}, 32'h7);
      check("R1", "hack/done/oe in reset", {29'd0, hold_ack_n, rsp_done, bus_oe}, 32'h4);
    end else begin
      check("R2", "cs_n", 32'(cs_n), 32'({!(on && m_region), !(on && !m_region)}));
      if (on) check("R2", "bus_addr", 32'(bus_addr), 32'(m_addr));
      check("R6", "rd_n", 32'(rd_n), 32'(!(on && !m_wr)));
      check("R5", "wrh_n", 32'(wrh_n), 32'(!(on && m_wr && m_be[1])));
      check("R5", "wrl_n", 32'(wrl_n), 32'(!(on && m_wr && m_be[0])));
      check("R5", "bus_oe", 32'(bus_oe), 32'(on && m_wr));
      if (on && m_wr) check("R5", "bus_dout", 32'(bus_dout), 32'(m_wdata));
      check("R3 R4 R7", "rsp_done", 32'(rsp_done), 32'(m_done));
      if (m_done) check("R8", "rsp_err", 32'(rsp_err), 32'(m_err));
      if (m_done && !m_err) check("R6", "rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
      check("R9", "hold_ack_n", 32'(hold_ack_n), 32'(m_phase != 2));
      check("R10", "req_ready", 32'(req_ready), 32'(m_phase == 0 && hold_req_n));
    end
  end

  task automatic access(logic [23:0] a, logic [1:0] be, bit wr, logic [15:0] wd,
                        logic [15:0] din, int lows, int low_from, bit hold_mid);
    bit r;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be; req_write = wr; req_wdata = wd; bus_din = din;
    forever begin
      #9 r = req_ready;
      @(posedge clk);
      if (r) break;
    end
    @(negedge clk);
    req_valid = 0;
    for (int j = 1; j < 40; j++) begin
      if (hold_mid && j == 1) hold_req_n = 0;
      wait_n = !(j >= low_from && j < low_from + lows);
      if (rsp_done) break;
      @(negedge clk);
    end
    wait_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3 R5 write, region 0 both bytes, shortest setting
        access(24'h000124, 2'b11, 1, 16'hBEEF, 16'h0, 0, 0, 0);
        // R2 R6 read, region 1 high byte, longest setting
        access(24'h200346, 2'b10, 0, 16'h0, 16'hA55A, 0, 0, 0);
        // R4 read, region 0 low byte, wait extension of 3
        access(24'h00ABCE, 2'b01, 0, 16'h0, 16'h1234, 3, 2, 0);
        // R4 R5 write, region 1 low byte only, extension of 1
        access(24'h3FFFFE, 2'b01, 1, 16'h00C3, 16'h0, 1, 5, 0);
        // R8 out-of-region tags
        access(24'h400000, 2'b11, 0, 16'h0, 16'hFFFF, 0, 0, 0);
        access(24'hE00010, 2'b11, 1, 16'h7777, 16'h0, 0, 0, 0);
        // R9 hold from idle with a request pending, R10 ready stays low
        @(negedge clk); hold_req_n = 0;
        repeat (3) @(negedge clk);
        req_valid = 1; req_addr = 24'h000200; req_be = 2'b11; req_write = 0; bus_din = 16'h5AA5;
        repeat (5) @(negedge clk);
        hold_req_n = 1;
        repeat (2) @(negedge clk);
        req_valid = 0;
        repeat (8) @(negedge clk);
        // R9 hold asserted mid-access
        access(24'h200400, 2'b11, 1, 16'h4321, 16'h0, 0, 0, 1);
        repeat (4) @(negedge clk);
        hold_req_n = 1;
        repeat (3) @(negedge clk);
        // R3 sweep of all region 0 settings
        for (int c = 0; c < 4; c++) begin
          wait_cfg0 = 2'(c);
          access(24'h000010 + 24'(c * 2), 2'b11, 0, 16'h0, 16'h0F00 + 16'(c), 0, 0, 0);
        end
        repeat (4) @(negedge clk);
      end
      begin
        while (cycles < 100000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      miscompares++;
      $display("FAIL watchdog expired: got %0d cycles expected < 100000", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule